// File: doc/BRIEF.md
# Slot-Table Bus Arbiter with Bandwidth Guarantees

This block decides which master owns a shared on-chip bus. Each peripheral master and the CPU has its own request line. Ownership is handed out one block transfer (burst) at a time. A programmable slot table decides who gets the bus. Several tables are stored, one for each arbitration mode, and a mode register picks the table in use.

The arbiter walks the active table one slot per burst. When the peripheral that owns the current slot is requesting, it gets the grant. When the owner is idle, the slot goes to the CPU if the CPU is requesting. Otherwise the slot is skipped. A grant lasts until the master signals that its burst is done, or until a fixed beat cap is reached. The next slot is arbitrated on the same clock edge, so no cycles are lost between bursts.

A peripheral that appears in the active table and keeps its request up is therefore granted within table-length times beat-cap cycles. The table contents decide how bandwidth is split between the peripherals. Software changes the split by rewriting table entries or by selecting another mode.

Top module: `bw_bus_arbiter`

## Requirements
- R1: After synchronous reset no grant is active, the slot pointer is at slot 0, mode 0 is selected, and in every table slot s is owned by peripheral s mod N_PERIPH.
- R2: At most one of grantPeriph bits and grantCpu is high in any cycle.
- R3: At an arbitration edge, if the peripheral named by the current slot of the active table is requesting, that peripheral alone is granted from the next cycle.
- R4: At an arbitration edge with the slot owner not requesting, the CPU is granted if reqCpu is high, otherwise no one is granted. The slot pointer advances by one (wrapping after TABLE_LEN-1) at every arbitration edge, whether the slot was used or not.
- R5: An arbitration edge is any edge with no grant active, or any edge at which the granted master drives burstDone high. The next slot is decided on that same edge, back to back.
- R6: A grant lasts at most MAX_BEATS cycles. It ends after its MAX_BEATS-th cycle even if burstDone never arrives.
- R7: A table write (tblWrEn high, with tblWrMode naming the table, tblWrSlot the slot index and tblWrOwner the peripheral index) updates that entry at the clock edge. It is used by the first arbitration after that edge.
- R8: A mode write (modeWrEn high with modeWrVal) never shortens or extends the burst in progress. The new table is used from the next arbitration edge onward.
- R9: A peripheral that owns at least one slot of the active table, and holds its request high, waits no more than TABLE_LEN*MAX_BEATS cycles for its grant.
- R10: Between arbitration edges the grant outputs do not change, even if requests drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqPeriph | input | N_PERIPH | Request lines, one per peripheral master |
| reqCpu | input | 1 | Request line of the CPU (default master) |
| burstDone | input | 1 | Granted master signals the last beat of its burst |
| tblWrEn | input | 1 | Slot table write strobe |
| tblWrMode | input | $clog2(NUM_MODES) | Table (mode) selected for the write |
| tblWrSlot | input | $clog2(TABLE_LEN) | Slot index written |
| tblWrOwner | input | $clog2(N_PERIPH) | Peripheral index stored in the slot |
| modeWrEn | input | 1 | Mode register write strobe |
| modeWrVal | input | $clog2(NUM_MODES) | New arbitration mode |
| grantPeriph | output | N_PERIPH | One-hot grant to a peripheral master |
| grantCpu | output | 1 | Grant to the CPU |

## Verification
Every grant output is a register, so the result of a decision shows up one cycle after the arbitration edge that took it. A table write or a mode write first affects the grants one cycle after the next arbitration edge. The bench keeps a behavioural model that steps on the same rising edge as the design, using the inputs driven on the previous falling edge. It compares both grant outputs on every falling edge, so each result is checked in exactly the cycle it is due. The wait of each peripheral is counted in edges from its request to its grant and compared with the TABLE_LEN*MAX_BEATS bound.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Strobes from the burst control to the slot datapath.
  typedef struct packed {
    logic arbitrate;  // decide a new slot at this edge
    logic beatTick;   // current grant continues through this edge
  } arb_strobe_t;

endpackage

// File: rtl/arb_burst_ctrl.sv
module arb_burst_ctrl
  import arb_pkg::*;
#(
  parameter int MAX_BEATS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        grantAny,
  input  logic        burstDone,
  output arb_strobe_t strobe
);

  localparam int BW = $clog2(MAX_BEATS + 1);

  logic [BW-1:0] beatCnt;
  logic          lastBeat;
  logic          burstEnd;

  assign lastBeat = (beatCnt == BW'(MAX_BEATS - 1));
  assign burstEnd = grantAny && (burstDone || lastBeat);

  always_comb begin
    strobe.arbitrate = !grantAny || burstEnd;
    strobe.beatTick  = grantAny && !burstEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt <= '0;
    end else if (strobe.arbitrate) begin
      beatCnt <= '0;
    end else begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  // R5: a burstDone during a grant always reopens arbitration
  assert_done_reopens_R5: assert property (@(posedge clk) disable iff (!rstN)
    (grantAny && burstDone) |-> strobe.arbitrate);

endmodule

// File: rtl/arb_slot_path.sv
module arb_slot_path
  import arb_pkg::*;
#(
  parameter int N_PERIPH  = 4,
  parameter int TABLE_LEN = 16,
  parameter int NUM_MODES = 2,
  parameter int MAX_BEATS = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  arb_strobe_t                  strobe,
  input  logic [N_PERIPH-1:0]          reqPeriph,
  input  logic                         reqCpu,
  input  logic                         tblWrEn,
  input  logic [$clog2(NUM_MODES)-1:0] tblWrMode,
  input  logic [$clog2(TABLE_LEN)-1:0] tblWrSlot,
  input  logic [$clog2(N_PERIPH)-1:0]  tblWrOwner,
  input  logic                         modeWrEn,
  input  logic [$clog2(NUM_MODES)-1:0] modeWrVal,
  output logic [N_PERIPH-1:0]          grantPeriph,
  output logic                         grantCpu,
  output logic                         grantAny
);

  localparam int OW        = $clog2(N_PERIPH);
  localparam int SW        = $clog2(TABLE_LEN);
  localparam int MW        = $clog2(NUM_MODES);
  localparam int WAIT_MAX  = TABLE_LEN * MAX_BEATS;
  localparam int WW        = $clog2(WAIT_MAX + 2);
  localparam int HW        = $clog2(MAX_BEATS + 1);

  logic [OW-1:0] slotTbl [NUM_MODES][TABLE_LEN];
  logic [SW-1:0] slotPtr;
  logic [MW-1:0] modeReg;
  logic [OW-1:0] owner;
  logic          ownerReq;
  logic [SW-1:0] slotNext;

  assign owner    = slotTbl[modeReg][slotPtr];
  assign ownerReq = reqPeriph[owner];
  assign slotNext = (slotPtr == SW'(TABLE_LEN - 1)) ? '0 : slotPtr + 1'b1;
  assign grantAny = (|grantPeriph) || grantCpu;

  // Slot tables and mode register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int m = 0; m < NUM_MODES; m++) begin
        for (int s = 0; s < TABLE_LEN; s++) begin
          slotTbl[m][s] <= OW'(s % N_PERIPH);
        end
      end
      modeReg <= '0;
    end else begin
      if (tblWrEn) slotTbl[tblWrMode][tblWrSlot] <= tblWrOwner;
      if (modeWrEn) modeReg <= modeWrVal;
    end
  end

  // Slot pointer and grant registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotPtr     <= '0;
      grantPeriph <= '0;
      grantCpu    <= 1'b0;
    end else if (strobe.arbitrate) begin
      slotPtr <= slotNext;
      if (ownerReq) begin
        grantPeriph <= N_PERIPH'(1) << owner;
        grantCpu    <= 1'b0;
      end else begin
        grantPeriph <= '0;
        grantCpu    <= reqCpu;
      end
    end
  end

  // ---------------- checks next to the logic ----------------
  logic [N_PERIPH-1:0] present;
  always_comb begin
    present = '0;
    for (int s = 0; s < TABLE_LEN; s++) begin
      present[slotTbl[modeReg][s]] = 1'b1;
    end
  end

  logic [HW-1:0] holdCnt;
  always_ff @(posedge clk) begin
    if (!rstN || strobe.arbitrate) holdCnt <= '0;
    else if (strobe.beatTick)      holdCnt <= holdCnt + 1'b1;
  end

  generate
    for (genvar i = 0; i < N_PERIPH; i++) begin : g_wait
      logic [WW-1:0] waitCnt;
      always_ff @(posedge clk) begin
        if (!rstN || tblWrEn || modeWrEn || !present[i]) waitCnt <= '0;
        else if (reqPeriph[i] && !grantPeriph[i])        waitCnt <= waitCnt + 1'b1;
        else                                             waitCnt <= '0;
      end
      assert_wait_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
        waitCnt <= WW'(WAIT_MAX));
    end
  endgenerate

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({grantPeriph, grantCpu}));

  assert_owner_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.arbitrate && ownerReq) |=> (grantPeriph[$past(owner)] && !grantCpu));

  assert_cpu_fill_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.arbitrate && !ownerReq && reqCpu) |=> (grantCpu && grantPeriph == '0));

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.arbitrate |=> ($stable(grantPeriph) && $stable(grantCpu)));

  assert_beat_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt < HW'(MAX_BEATS));

endmodule

// File: rtl/bw_bus_arbiter.sv
module bw_bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_PERIPH  = 4,
  parameter int TABLE_LEN = 16,
  parameter int NUM_MODES = 2,
  parameter int MAX_BEATS = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [N_PERIPH-1:0]          reqPeriph,
  input  logic                         reqCpu,
  input  logic                         burstDone,
  input  logic                         tblWrEn,
  input  logic [$clog2(NUM_MODES)-1:0] tblWrMode,
  input  logic [$clog2(TABLE_LEN)-1:0] tblWrSlot,
  input  logic [$clog2(N_PERIPH)-1:0]  tblWrOwner,
  input  logic                         modeWrEn,
  input  logic [$clog2(NUM_MODES)-1:0] modeWrVal,
  output logic [N_PERIPH-1:0]          grantPeriph,
  output logic                         grantCpu
);

  arb_strobe_t strobe;
  logic        grantAny;

  arb_burst_ctrl #(.MAX_BEATS(MAX_BEATS)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .grantAny  (grantAny),
    .burstDone (burstDone),
    .strobe    (strobe)
  );

  arb_slot_path #(
    .N_PERIPH  (N_PERIPH),
    .TABLE_LEN (TABLE_LEN),
    .NUM_MODES (NUM_MODES),
    .MAX_BEATS (MAX_BEATS)
  ) i_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqPeriph   (reqPeriph),
    .reqCpu      (reqCpu),
    .tblWrEn     (tblWrEn),
    .tblWrMode   (tblWrMode),
    .tblWrSlot   (tblWrSlot),
    .tblWrOwner  (tblWrOwner),
    .modeWrEn    (modeWrEn),
    .modeWrVal   (modeWrVal),
    .grantPeriph (grantPeriph),
    .grantCpu    (grantCpu),
    .grantAny    (grantAny)
  );

endmodule

// File: tb/test_bw_bus_arbiter.sv
module test_bw_bus_arbiter;

  localparam int NP = 4;
  localparam int TL = 16;
  localparam int MB = 8;
  localparam int CPU = NP;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] reqPeriph = '0;
  logic          reqCpu = 1'b0;
  logic          burstDone = 1'b0;
  logic          tblWrEn = 1'b0;
  logic [0:0]    tblWrMode = '0;
  logic [3:0]    tblWrSlot = '0;
  logic [1:0]    tblWrOwner = '0;
  logic          modeWrEn = 1'b0;
  logic [0:0]    modeWrVal = '0;
  logic [NP-1:0] grantPeriph;
  logic          grantCpu;

  always #4 clk = ~clk;  // 125 MHz

  bw_bus_arbiter i_bw_bus_arbiter (
    .clk(clk), .rstN(rstN), .reqPeriph(reqPeriph), .reqCpu(reqCpu),
    .burstDone(burstDone), .tblWrEn(tblWrEn), .tblWrMode(tblWrMode),
    .tblWrSlot(tblWrSlot), .tblWrOwner(tblWrOwner), .modeWrEn(modeWrEn),
    .modeWrVal(modeWrVal), .grantPeriph(grantPeriph), .grantCpu(grantCpu)
  );

  int checks = 0;
  int fails = 0;
  string curTag = "R1";
  bit waitPhase = 0;

  // reference model state
  int mTbl [2][TL];
  int mPtr, mMode, mBeat, mOwner;
  int blen [NP+1];
  int waitCnt [NP];
  bit mPresent [NP];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Model steps on the same edge as the design
  always @(posedge clk) begin
    if (!rstN) begin
      for (int m = 0; m < 2; m++)
        for (int s = 0; s < TL; s++) mTbl[m][s] = s % NP;
      mPtr = 0; mMode = 0; mBeat = 0; mOwner = -1;
      for (int i = 0; i < NP; i++) waitCnt[i] = 0;
    end else begin
      bit free;
      free = (mOwner < 0) || burstDone || (mBeat == MB - 1);
      if (free) begin
        int o;
        o = mTbl[mMode][mPtr];
        if (reqPeriph[o]) mOwner = o;
        else if (reqCpu)  mOwner = CPU;
        else              mOwner = -1;
        mPtr = (mPtr + 1) % TL;
        mBeat = 0;
      end else begin
        mBeat++;
      end
      if (tblWrEn) mTbl[tblWrMode][tblWrSlot] = tblWrOwner;
      if (modeWrEn) mMode = modeWrVal;
      for (int i = 0; i < NP; i++) begin
        mPresent[i] = 0;
        for (int s = 0; s < TL; s++) if (mTbl[mMode][s] == i) mPresent[i] = 1;
      end
      // R9: wait in edges from request to grant
      for (int i = 0; i < NP; i++) begin
        if (mOwner == i) begin
          if (waitPhase && mPresent[i])
            check(waitCnt[i] <= TL * MB, "R9", "wait cycles", waitCnt[i], TL * MB);
          waitCnt[i] = 0;
        end else if (reqPeriph[i]) waitCnt[i]++;
        else waitCnt[i] = 0;
      end
    end
  end

  // Compare every cycle and produce the masters' burstDone
  always @(negedge clk) begin
    if (rstN) begin
      logic [NP-1:0] expP;
      expP = (mOwner >= 0 && mOwner < NP) ? (NP'(1) << mOwner) : '0;
      check(grantPeriph == expP, curTag, "grantPeriph", int'(grantPeriph), int'(expP));
      check(grantCpu == (mOwner == CPU), curTag, "grantCpu", int'(grantCpu), int'(mOwner == CPU));
      burstDone <= (mOwner >= 0) && (mBeat == blen[mOwner] - 1);
    end else begin
      burstDone <= 1'b0;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setBlen(int all, int cpuLen);
    for (int i = 0; i < NP; i++) blen[i] = all;
    blen[CPU] = cpuLen;
  endtask

  task automatic writeSlot(int m, int s, int o);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrMode = 1'(m); tblWrSlot = 4'(s); tblWrOwner = 2'(o);
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  task automatic writeMode(int m);
    @(negedge clk);
    modeWrEn = 1'b1; modeWrVal = 1'(m);
    @(negedge clk);
    modeWrEn = 1'b0;
  endtask

  initial begin
    setBlen(3, 3);
    cycles(4);
    check(grantPeriph == '0 && grantCpu == 1'b0, "R1", "grants in reset",
          int'({grantPeriph, grantCpu}), 0);
    rstN = 1'b1;
    cycles(2);
    check(grantPeriph == '0 && grantCpu == 1'b0, "R1", "idle after reset",
          int'({grantPeriph, grantCpu}), 0);

    // R3/R5: everyone requests, default round-robin table, short bursts
    curTag = "R3";
    reqPeriph = 4'hF; reqCpu = 1'b1;
    cycles(60);
    curTag = "R5";
    setBlen(1, 2);
    cycles(40);

    // R4: only the CPU, then nobody, then a sparse peripheral
    curTag = "R4";
    reqPeriph = '0;
    cycles(30);
    reqCpu = 1'b0;
    cycles(20);
    reqPeriph = 4'b0100; reqCpu = 1'b1;
    cycles(40);

    // R6/R10: bursts never signalled done, requests drop mid-burst
    curTag = "R6";
    setBlen(100, 100);
    reqPeriph = 4'hF;
    cycles(70);
    curTag = "R10";
    cycles(3);
    reqPeriph = '0; reqCpu = 1'b0;
    cycles(20);

    // R7: program table 1; slot 15 only for peripheral 3, peripheral 0 absent
    curTag = "R7";
    for (int s = 0; s < TL; s++)
      writeSlot(1, s, (s == TL - 1) ? 3 : ((s < 8) ? 2 : 1));
    writeSlot(0, 0, 3);
    reqPeriph = 4'hF; reqCpu = 1'b1;
    setBlen(5, 5);
    cycles(40);

    // R8: mode switch in the middle of a burst
    curTag = "R8";
    setBlen(100, 100);
    while (!(mOwner >= 0 && mBeat == 2)) @(negedge clk);
    writeMode(1);
    cycles(80);
    writeMode(0);
    cycles(30);
    writeMode(1);

    // R9: CPU hogs with full bursts; peripherals 1..3 request at random
    curTag = "R9";
    reqPeriph = '0;
    cycles(10);
    waitPhase = 1;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      for (int i = 1; i < NP; i++) begin
        if (mOwner == i) reqPeriph[i] = 1'b0;
        else if (!reqPeriph[i] && ($urandom % 16 == 0)) reqPeriph[i] = 1'b1;
      end
    end
    waitPhase = 0;
    reqPeriph = '0; reqCpu = 1'b0;
    cycles(20);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule